// File: doc/BRIEF.md
# Four-Channel Prescaled Pulse Width Modulator

This block generates four independent pulse-width-modulated outputs from one clock. Software programs it through a small word-addressed register bus. A shared control word holds one run bit for each channel, and next to those bits a 2-bit step-rate select for each channel. Each channel also has its own configuration word, which holds a period length and a high-time length. Both lengths are counted in steps, and a step is the input clock divided by the channel's selected factor.

Each channel's divider is two cascaded stages. The first stage divides by 8 and the second by 64. Either stage can be bypassed, so a channel can step every 1, 8, 64 or 512 clock cycles. Within each period the output is high for the first `duty` steps and low for the rest. A new configuration is copied into a channel's working copy only at a period boundary, so a period in progress is never cut short. Clearing a run bit stops that channel at once.

Top module: `pwm_quad`

## Requirements
- R1: After reset, and at once while `rst_n` is low, every output is low and every register reads 0. Internal logic leaves reset two clock edges after `rst_n` rises.
- R2: `bus_addr` is a word index, and a write (`bus_we`=1) takes effect at the clock edge. Word 0 is control: bits [3:0] are the run bits of channels 3..0, and bits [2n+5:2n+4] are channel n's select. Word 1+n is channel n's configuration: bits [7:0] hold the period in steps and bits [31:16] hold the duty in steps. `bus_rdata` shows the addressed word combinationally and returns the stored fields. All other bits, including configuration bits [15:8], are dropped on write and read as 0.
- R3: Words 5, 6 and 7 read as 0, and writes to them change no register.
- R4: A channel whose run bit is set repeats a period of T steps, where T is the period field. Its output is high for the first D steps of each period, where D is the duty field. The write that sets the run bit starts a new period, with the output showing step 0 in the cycle after that write.
- R5: A duty of 0 keeps the output low for the whole period. A duty equal to or above the period keeps it high for the whole period.
- R6: A period field of 0 keeps the output low while the channel runs.
- R7: A select code of 0, 1, 2 or 3 gives a step of 1, 8, 64 or 512 clock cycles.
- R8: A configuration or select written while a channel runs is used from that channel's next period boundary onward. A value written at the same edge as a boundary, or at the same edge as the run-set write, is used from that edge.
- R9: Clearing a run bit drives that output low from the cycle after the write and clears the channel's step and divider counters. Setting the bit again starts a new period.
- R10: Channels run independently, each with its own period, duty and select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 3 | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| pwm_out | output | 4 | Channel outputs, bit n is channel n |

## Verification
A register write is visible on `bus_rdata` right after the clock edge that takes it, and a read needs no clock at all. A channel's output first shows a run or configuration change in the cycle after the write edge. After that the output advances one step every 1, 8, 64 or 512 cycles, depending on the select. The bench drives inputs on falling edges and samples on falling edges. It numbers each sample by how many rising edges have passed since the write that started the channel, so every expected level is computed for exactly that cycle. The only exception is the reset check, which samples one time unit after `rst_n` falls, because reset clears the block at once.

// File: rtl/pwm_quad_pkg.sv
package pwm_quad_pkg;

  // Field layout of the configuration word.
  localparam int CFG_TB_LSB   = 0;
  localparam int CFG_DUTY_LSB = 16;

  // Lowest bit of channel n's select field: the selects sit just above the run bits.
  function automatic int sel_lsb(input int nch, input int sel_w, input int n);
    return nch + sel_w * n;
  endfunction

endpackage

// File: rtl/pwm_quad_regs.sv
module pwm_quad_regs
  import pwm_quad_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int DUTY_W = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               we,
  input  logic [ADDR_W-1:0]                  addr,
  input  logic [DATA_W-1:0]                  wdata,
  output logic [DATA_W-1:0]                  rdata,
  output logic [NUM_CH-1:0]                  run_q,
  output logic [NUM_CH-1:0][SEL_W-1:0]       sel_q,
  output logic [NUM_CH-1:0][TB_W-1:0]        tb_q,
  output logic [NUM_CH-1:0][DUTY_W-1:0]      duty_q,
  output logic [NUM_CH-1:0][SEL_W-1:0]       sel_d,
  output logic [NUM_CH-1:0][TB_W-1:0]        tb_d,
  output logic [NUM_CH-1:0][DUTY_W-1:0]      duty_d
);

  logic              ctrl_en;
  logic [NUM_CH-1:0] cfg_en;
  logic [NUM_CH-1:0] run_d;
  logic              unused_wdata;

  assign unused_wdata = ^wdata;

  // Next state for every register, together with its write enable.
  always_comb begin
    ctrl_en = we && (addr == '0);
    run_d   = ctrl_en ? wdata[NUM_CH-1:0] : run_q;
    for (int n = 0; n < NUM_CH; n++) begin
      cfg_en[n] = we && (addr == ADDR_W'(n + 1));
      sel_d[n]  = ctrl_en   ? wdata[sel_lsb(NUM_CH, SEL_W, n) +: SEL_W] : sel_q[n];
      tb_d[n]   = cfg_en[n] ? wdata[CFG_TB_LSB +: TB_W]                : tb_q[n];
      duty_d[n] = cfg_en[n] ? wdata[CFG_DUTY_LSB +: DUTY_W]            : duty_q[n];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= '0;
      sel_q  <= '0;
      tb_q   <= '0;
      duty_q <= '0;
    end else begin
      if (ctrl_en) begin
        run_q <= run_d;
        sel_q <= sel_d;
      end
      for (int n = 0; n < NUM_CH; n++) begin
        if (cfg_en[n]) begin
          tb_q[n]   <= tb_d[n];
          duty_q[n] <= duty_d[n];
        end
      end
    end
  end

  // Combinational read mux; any unmapped word or bit reads as zero.
  always_comb begin
    rdata = '0;
    if (addr == '0) begin
      rdata[NUM_CH-1:0] = run_q;
      for (int n = 0; n < NUM_CH; n++) begin
        rdata[sel_lsb(NUM_CH, SEL_W, n) +: SEL_W] = sel_q[n];
      end
    end
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr == ADDR_W'(n + 1)) begin
        rdata[CFG_TB_LSB +: TB_W]     = tb_q[n];
        rdata[CFG_DUTY_LSB +: DUTY_W] = duty_q[n];
      end
    end
  end

endmodule

// File: rtl/pwm_quad_presc.sv
module pwm_quad_presc #(
  parameter int STAGES  = 2,
  parameter int STAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              run,
  input  logic [STAGES-1:0] sel,
  output logic              tick
);

  logic [STAGES:0] chain;

  assign chain[0] = run;

  // Stage s divides by 2**(STAGE_W << s) when its select bit is set, and passes straight through otherwise.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      localparam int W = STAGE_W << s;
      logic [W-1:0] c_q;
      logic [W-1:0] c_d;
      logic         adv;

      assign adv          = sel[s] && chain[s];
      assign chain[s + 1] = sel[s] ? (chain[s] && (&c_q)) : chain[s];

      always_comb c_d = clr ? '0 : (c_q + W'(1));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          c_q <= '0;
        end else if (clr || adv) begin
          c_q <= c_d;
        end
      end
    end
  endgenerate

  assign tick = chain[STAGES];

endmodule

// File: rtl/pwm_quad_chan.sv
module pwm_quad_chan #(
  parameter int TB_W     = 8,
  parameter int DUTY_W   = 16,
  parameter int SEL_W    = 2,
  parameter int STAGE_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [TB_W-1:0]   cfg_tb,
  input  logic [DUTY_W-1:0] cfg_duty,
  input  logic [SEL_W-1:0]  cfg_sel,
  output logic              pwm_o
);

  logic [TB_W-1:0]   cnt_q, cnt_d;
  logic [TB_W-1:0]   tb_q, tb_d;
  logic [DUTY_W-1:0] duty_q, duty_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              tick;
  logic              last_step;
  logic              load;

  pwm_quad_presc #(
    .STAGES  (SEL_W),
    .STAGE_W (STAGE_W)
  ) u_presc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (load),
    .run   (run),
    .sel   (sel_q),
    .tick  (tick)
  );

  // Working settings are copied from the register side only when stopped, when the period is empty, or at the final step.
  always_comb begin
    last_step = (cnt_q == (tb_q - TB_W'(1)));
    load      = !run || (tb_q == '0) || (tick && last_step);
    if (load) begin
      cnt_d  = '0;
      tb_d   = cfg_tb;
      duty_d = cfg_duty;
      sel_d  = cfg_sel;
    end else begin
      cnt_d  = cnt_q + TB_W'(1);
      tb_d   = tb_q;
      duty_d = duty_q;
      sel_d  = sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tb_q   <= '0;
      duty_q <= '0;
      sel_q  <= '0;
    end else begin
      if (load || tick) begin
        cnt_q <= cnt_d;
      end
      if (load) begin
        tb_q   <= tb_d;
        duty_q <= duty_d;
        sel_q  <= sel_d;
      end
    end
  end

  assign pwm_o = run && (tb_q != '0) && (DUTY_W'(cnt_q) < duty_q);

endmodule

// File: rtl/pwm_quad.sv
module pwm_quad #(
  parameter int NUM_CH     = 4,
  parameter int TB_W       = 8,
  parameter int DUTY_W     = 16,
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 3,
  parameter int PS_STAGES  = 2,
  parameter int PS_STAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] pwm_out
);

  localparam int SEL_W = PS_STAGES;

  logic [1:0]                        rst_pipe;
  logic                              rst_sync_n;
  logic [NUM_CH-1:0]                 run_q;
  logic [NUM_CH-1:0][SEL_W-1:0]      sel_q, sel_d;
  logic [NUM_CH-1:0][TB_W-1:0]       tb_q, tb_d;
  logic [NUM_CH-1:0][DUTY_W-1:0]     duty_q, duty_d;

  // Reset is asserted asynchronously and released two edges later, in step with the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe[1];

  pwm_quad_regs #(
    .NUM_CH (NUM_CH),
    .TB_W   (TB_W),
    .DUTY_W (DUTY_W),
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .SEL_W  (SEL_W)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .we     (bus_we),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .rdata  (bus_rdata),
    .run_q  (run_q),
    .sel_q  (sel_q),
    .tb_q   (tb_q),
    .duty_q (duty_q),
    .sel_d  (sel_d),
    .tb_d   (tb_d),
    .duty_d (duty_d)
  );

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
      pwm_quad_chan #(
        .TB_W    (TB_W),
        .DUTY_W  (DUTY_W),
        .SEL_W   (SEL_W),
        .STAGE_W (PS_STAGE_W)
      ) u_chan (
        .clk      (clk),
        .rst_n    (rst_sync_n),
        .run      (run_q[n]),
        .cfg_tb   (tb_d[n]),
        .cfg_duty (duty_d[n]),
        .cfg_sel  (sel_d[n]),
        .pwm_o    (pwm_out[n])
      );
    end
  endgenerate

endmodule

// File: rtl/pwm_quad_chk.sv
module pwm_quad_chk #(
  parameter int NUM_CH = 4,
  parameter int TB_W   = 8,
  parameter int DUTY_W = 16,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 3,
  parameter int SEL_W  = 2
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          bus_we,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [DATA_W-1:0]             bus_wdata,
  input logic [DATA_W-1:0]             bus_rdata,
  input logic [NUM_CH-1:0]             run_vec,
  input logic [NUM_CH-1:0][SEL_W-1:0]  sel_vec,
  input logic [NUM_CH-1:0][TB_W-1:0]   tb_vec,
  input logic [NUM_CH-1:0][DUTY_W-1:0] duty_vec,
  input logic [NUM_CH-1:0]             pwm_out
);

  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pwm_out == '0) && (run_vec == '0));

  a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr == '0)) |=> (run_vec == $past(bus_wdata[NUM_CH-1:0])));

  a_r3_undef_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && (bus_addr > ADDR_W'(NUM_CH))) |=>
      ($stable(run_vec) && $stable(sel_vec) && $stable(tb_vec) && $stable(duty_vec)));

  a_r3_undef_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr > ADDR_W'(NUM_CH)) |-> (bus_rdata == '0));

  generate
    for (genvar n = 0; n < NUM_CH; n++) begin : g_stop
      a_r9_stopped_low: assert property (@(posedge clk) disable iff (!rst_n)
        !run_vec[n] |-> !pwm_out[n]);
    end
  endgenerate

endmodule

bind pwm_quad pwm_quad_chk #(
  .NUM_CH (NUM_CH),
  .TB_W   (TB_W),
  .DUTY_W (DUTY_W),
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W),
  .SEL_W  (PS_STAGES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .run_vec   (run_q),
  .sel_vec   (sel_q),
  .tb_vec    (tb_q),
  .duty_vec  (duty_q),
  .pwm_out   (pwm_out)
);

// File: tb/pwm_quad_bench.sv
`timescale 1ns/1ps
module pwm_quad_bench;

  localparam int HALF = 5;

  typedef struct packed {
    logic [2:0]  a;
    logic [31:0] d;
    logic [31:0] e;
  } vec_t;

  localparam vec_t TABLE [8] = '{
    '{3'd0, 32'hFFFF_FFF0, 32'h0000_0FF0},
    '{3'd0, 32'h0000_0000, 32'h0000_0000},
    '{3'd1, 32'h0080_0010, 32'h0080_0010},
    '{3'd2, 32'hFFFF_FFFF, 32'hFFFF_00FF},
    '{3'd3, 32'h1234_5678, 32'h1234_0078},
    '{3'd4, 32'h0001_0100, 32'h0001_0000},
    '{3'd5, 32'hFFFF_FFFF, 32'h0000_0000},
    '{3'd7, 32'hDEAD_BEEF, 32'h0000_0000}
  };

  logic        clk;
  logic        rst_n;
  logic        bus_we;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [3:0]  pwm_out;

  int  n_vec;
  int  n_bad;
  bit  done;

  pwm_quad u_pwm_quad (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pwm_out   (pwm_out)
  );

  initial clk = 1'b0;
  always #HALF clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a falling edge; the write is taken at the next rising edge and the task returns at the following falling edge.
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_we    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_we    = 1'b0;
    bus_addr  = 3'd0;
    bus_wdata = '0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    bus_addr = a;
    #1;
    chk(tag, bus_rdata, exp);
  endtask

  // Sample position k is the falling edge k rising edges after the starting write.
  task automatic watch(input int ch, input int n, input int step, input int tb,
                       input int duty, input string tag);
    for (int k = 0; k < n; k++) begin
      chk(tag, 32'(pwm_out[ch]), 32'((((k / step) % tb) < duty) ? 1 : 0));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog (all requirements): actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    n_vec     = 0;
    n_bad     = 0;
    done      = 1'b0;
    rst_n     = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = 3'd0;
    bus_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: state after reset.
    chk("R1 outputs after reset", 32'(pwm_out), 32'h0);
    for (int a = 0; a < 8; a++) rd_chk(3'(a), 32'h0, "R1 register after reset");

    // R2 / R3: register vector table.
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      wr(TABLE[v].a, TABLE[v].d);
      rd_chk(TABLE[v].a, TABLE[v].e, (TABLE[v].a > 3'd4) ? "R3 undefined word" : "R2 readback");
    end
    // R3: the undefined writes above left the defined words untouched.
    rd_chk(3'd0, 32'h0000_0000, "R3 control kept");
    rd_chk(3'd1, 32'h0080_0010, "R3 cfg0 kept");
    rd_chk(3'd2, 32'hFFFF_00FF, "R3 cfg1 kept");
    rd_chk(3'd3, 32'h1234_0078, "R3 cfg2 kept");
    rd_chk(3'd4, 32'h0001_0000, "R3 cfg3 kept");
    @(negedge clk);

    // R4: channel 0, period 10, duty 3, no division.
    wr(3'd1, 32'h0003_000A);
    wr(3'd0, 32'h0000_0001);
    watch(0, 22, 1, 10, 3, "R4 basic waveform");
    // R9: stop while the output is high (position 22, step 2).
    wr(3'd0, 32'h0000_0000);
    watch(0, 5, 1, 1, 0, "R9 stop forces low");

    // R8: a configuration change while running waits for the boundary.
    wr(3'd0, 32'h0000_0001);
    watch(0, 5, 1, 10, 3, "R8 before update");
    wr(3'd1, 32'h0004_0006);
    for (int k = 6; k < 28; k++) begin
      chk("R8 deferred update", 32'(pwm_out[0]),
          32'(((k < 10) ? (k < 3) : (((k - 10) % 6) < 4)) ? 1 : 0));
      @(negedge clk);
    end
    // R9: stop, then restart with a fresh period.
    wr(3'd0, 32'h0000_0000);
    watch(0, 3, 1, 1, 0, "R9 held low");
    wr(3'd0, 32'h0000_0001);
    watch(0, 12, 1, 6, 4, "R9 fresh period");

    // R7: step-rate selects 1, 2 and 3 on channels 1..3.
    wr(3'd0, 32'h0000_0000);
    wr(3'd2, 32'h0002_0004);
    wr(3'd3, 32'h0001_0002);
    wr(3'd4, 32'h0001_0002);
    wr(3'd0, 32'h0000_0042);
    watch(1, 64, 8, 4, 2, "R7 select 1 step 8");
    wr(3'd0, 32'h0000_0204);
    watch(2, 256, 64, 2, 1, "R7 select 2 step 64");
    wr(3'd0, 32'h0000_0C08);
    watch(3, 2048, 512, 2, 1, "R7 select 3 step 512");

    // R5, R6, R10: duty 0, duty above period, period 0 and duty equal to period, all running at once.
    wr(3'd0, 32'h0000_0000);
    wr(3'd1, 32'h0000_0005);
    wr(3'd2, 32'h0014_0005);
    wr(3'd3, 32'h0005_0000);
    wr(3'd4, 32'h0005_0005);
    wr(3'd0, 32'h0000_000F);
    for (int k = 0; k < 15; k++) begin
      chk("R5 R6 R10 fixed levels", 32'(pwm_out), 32'h0000_000A);
      @(negedge clk);
    end

    // R1: reset asserted while running clears the block at once.
    rst_n = 1'b0;
    #1;
    chk("R1 async reset outputs", 32'(pwm_out), 32'h0);
    for (int a = 0; a < 5; a++) rd_chk(3'(a), 32'h0, "R1 async reset registers");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 outputs after release", 32'(pwm_out), 32'h0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule